// File: doc/BRIEF.md
# Phase Voltage Router

This block sits between three phase-voltage sample streams (sources A, B and C) and three computational datapaths (paths A, B and C). A configuration register holds one 2-bit routing code per source. Each code chooses which path that source's samples go to. A power engine behind a path can therefore pair its own current with the voltage of a different phase. The router drops no sample on a routed source and splits no sample between sources.

Every source and every path is a valid/ready stream. A transfer happens on a clock edge where valid and ready are both high. A source must hold its valid and data steady until it is accepted. Each path has a one-entry output register. A path keeps its valid and data stable while its ready is low. A source that wins a path sees ready only when that path's register is empty or draining in the same cycle. A source that loses arbitration, or whose target is already claimed, sees ready held high and its samples are discarded. The router never back-pressures it.

The host writes the register through a plain write strobe and reads it back on a plain data bus. A new routing takes effect only at a sample boundary. That is a cycle in which no path holds a sample that is not being taken.

Top module: `phase_vroute`

## Requirements
- R1: After reset the register reads zero. After a write, the read bus returns the written bits [13:8] and every other bit reads zero.
- R2: Code bits [9:8] steer source A: 00 goes to path A, 01 to path B, 10 to path C.
- R3: Code bits [11:10] steer source B: 00 goes to path B, 01 to path C, 10 to path A.
- R4: Code bits [13:12] steer source C: 00 goes to path C, 01 to path A, 10 to path B.
- R5: For every source, code 11 routes exactly as code 00.
- R6: When all three codes are 01, path A carries source C's samples, path B carries source A's and path C carries source B's.
- R7: When several sources target one path, the source with the lowest letter wins. A losing source's samples are accepted (ready high) and appear on no path.
- R8: A path that no source targets keeps its valid low and its data at zero.
- R9: A new routing is applied only on an edge where every path's register is empty or draining. While any path stalls, samples keep being routed by the previous setting, and a stalled sample is never altered.
- R10: A path whose valid is high and whose ready is low holds valid and data unchanged on the next cycle. The winning source's ready is low while its path register is full and not draining.
- R11: A sample accepted on an edge appears on its path with valid high right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | CFG_W | Register write data |
| cfg_rd_data | output | CFG_W | Register read data |
| vin_valid | input | 3 | Per-source sample valid (bit 0 = A) |
| vin_ready | output | 3 | Per-source sample ready |
| vin_data | input | 3 x DATA_W | Per-source voltage sample |
| path_valid | output | 3 | Per-path sample valid |
| path_ready | input | 3 | Per-path sample ready |
| path_data | output | 3 x DATA_W | Per-path voltage sample |

## Verification
The hardest case to reach from the ports is a configuration write that lands while a path is stalled. In that case the old routing must remain in force for several more samples. The bench holds path A's ready low with a sample parked in its register, then writes the full-rotation setting. It then sends a sample on source B, which must still arrive on path B and not on path C. After that it releases path A and checks that the next sample from source A goes to path B. A scoreboard tracks each path's expected samples in order and flags any sample that shows up unannounced, which is how discarded arbitration losers are caught.

// File: rtl/pvr_pkg.sv
package pvr_pkg;
  localparam int NPH        = 3;
  localparam int CODE_W     = 2;
  localparam int FIELD_LSB  = 8;
  localparam int FIELD_SPAN = NPH * CODE_W;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [1:0]        idx_t;

  // Destination path of a source: rotation by the code, with 11 folded to 00.
  function automatic idx_t dest_of(input int unsigned src, input code_t c);
    int unsigned step;
    int unsigned d;
    step = (c == 2'b11) ? 0 : int'(unsigned'(c));
    d = src + step;
    if (d >= NPH) d = d - NPH;
    return idx_t'(d);
  endfunction
endpackage

// File: rtl/pvr_cfg_regs.sv
module pvr_cfg_regs
  import pvr_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [CFG_W-1:0]      wr_data,
  output logic [CFG_W-1:0]      rd_data,
  output code_t [NPH-1:0]       codes
);
  logic [FIELD_SPAN-1:0] fld_q;
  logic                  unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fld_q <= '0;
    end else if (wr_en) begin
      fld_q <= wr_data[FIELD_LSB +: FIELD_SPAN];
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[FIELD_LSB +: FIELD_SPAN] = fld_q;
  end

  for (genvar g = 0; g < NPH; g++) begin : g_code
    assign codes[g] = fld_q[g*CODE_W +: CODE_W];
  end
endmodule

// File: rtl/pvr_route_map.sv
module pvr_route_map
  import pvr_pkg::*;
(
  input  code_t [NPH-1:0] codes,
  output idx_t  [NPH-1:0] dest,
  output logic  [NPH-1:0] path_has,
  output idx_t  [NPH-1:0] path_src,
  output logic  [NPH-1:0] src_win
);
  for (genvar g = 0; g < NPH; g++) begin : g_dest
    assign dest[g] = dest_of(g, codes[g]);
  end

  // Scan from the highest letter down so the lowest letter is written last.
  always_comb begin
    for (int p = 0; p < NPH; p++) begin
      path_has[p] = 1'b0;
      path_src[p] = '0;
      for (int s = NPH - 1; s >= 0; s--) begin
        if (dest[s] == idx_t'(p)) begin
          path_has[p] = 1'b1;
          path_src[p] = idx_t'(s);
        end
      end
    end
  end

  for (genvar g = 0; g < NPH; g++) begin : g_win
    assign src_win[g] = (path_src[dest[g]] == idx_t'(g));
  end
endmodule

// File: rtl/pvr_path_slot.sv
module pvr_path_slot #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              free
);
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  assign free      = ~vld_q | out_ready;
  assign out_valid = vld_q;
  assign out_data  = vld_q ? dat_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (load) begin
      vld_q <= 1'b1;
      dat_q <= load_data;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/phase_vroute.sv
module phase_vroute
  import pvr_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CFG_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_wr_en,
  input  logic [CFG_W-1:0]             cfg_wr_data,
  output logic [CFG_W-1:0]             cfg_rd_data,
  input  logic [NPH-1:0]               vin_valid,
  output logic [NPH-1:0]               vin_ready,
  input  logic [NPH-1:0][DATA_W-1:0]   vin_data,
  output logic [NPH-1:0]               path_valid,
  input  logic [NPH-1:0]               path_ready,
  output logic [NPH-1:0][DATA_W-1:0]   path_data
);
  code_t [NPH-1:0] reg_codes;
  code_t [NPH-1:0] map_q;
  idx_t  [NPH-1:0] dest;
  idx_t  [NPH-1:0] path_src;
  logic  [NPH-1:0] path_has;
  logic  [NPH-1:0] src_win;
  logic  [NPH-1:0] slot_free;
  logic  [NPH-1:0] load;
  logic            boundary;

  pvr_cfg_regs #(.CFG_W(CFG_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .rd_data (cfg_rd_data),
    .codes   (reg_codes)
  );

  // Active routing is only refreshed at a sample boundary.
  assign boundary = &slot_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q <= '0;
    end else if (boundary) begin
      map_q <= reg_codes;
    end
  end

  pvr_route_map u_map (
    .codes    (map_q),
    .dest     (dest),
    .path_has (path_has),
    .path_src (path_src),
    .src_win  (src_win)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_path
    assign load[p] = path_has[p] & vin_valid[path_src[p]] & slot_free[p];

    pvr_path_slot #(.DATA_W(DATA_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load[p]),
      .load_data (vin_data[path_src[p]]),
      .out_ready (path_ready[p]),
      .out_valid (path_valid[p]),
      .out_data  (path_data[p]),
      .free      (slot_free[p])
    );
  end

  for (genvar s = 0; s < NPH; s++) begin : g_src
    assign vin_ready[s] = src_win[s] ? slot_free[dest[s]] : 1'b1;
  end
endmodule

// File: rtl/phase_vroute_checker.sv
module phase_vroute_checker
  import pvr_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CFG_W  = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [CFG_W-1:0]           cfg_rd_data,
  input logic [NPH-1:0]             path_valid,
  input logic [NPH-1:0]             path_ready,
  input logic [NPH-1:0][DATA_W-1:0] path_data,
  input logic [NPH-1:0]             load,
  input logic [NPH-1:0]             path_has,
  input idx_t [NPH-1:0]             path_src,
  input code_t [NPH-1:0]            map_q
);
  logic [CFG_W-1:0]          field_mask;
  logic [NPH-1:0][NPH-1:0]   src_loads;

  always_comb begin
    field_mask = '0;
    field_mask[FIELD_LSB +: FIELD_SPAN] = '1;
    for (int s = 0; s < NPH; s++) begin
      for (int p = 0; p < NPH; p++) begin
        src_loads[s][p] = load[p] && (path_src[p] == idx_t'(s));
      end
    end
  end

  a_r1_rd_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data & ~field_mask) == '0);

  a_r9_map_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (|(path_valid & ~path_ready)) |=> $stable(map_q));

  for (genvar p = 0; p < NPH; p++) begin : g_path
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (path_valid[p] && !path_ready[p]) |=> (path_valid[p] && $stable(path_data[p])));

    a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
      load[p] |=> path_valid[p]);

    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!path_has[p] && !path_valid[p]) |=> (!path_valid[p] && path_data[p] == '0));
  end

  for (genvar s = 0; s < NPH; s++) begin : g_src
    a_r7_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(src_loads[s]) <= 1);
  end
endmodule

bind phase_vroute phase_vroute_checker #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_rd_data (cfg_rd_data),
  .path_valid  (path_valid),
  .path_ready  (path_ready),
  .path_data   (path_data),
  .load        (load),
  .path_has    (path_has),
  .path_src    (path_src),
  .map_q       (map_q)
);

// File: tb/phase_vroute_test.sv
module phase_vroute_test;
  localparam int DW = 24;
  localparam int CW = 16;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cfg_wr_en = 1'b0;
  logic [CW-1:0]      cfg_wr_data = '0;
  logic [CW-1:0]      cfg_rd_data;
  logic [2:0]         vin_valid = '0;
  logic [2:0]         vin_ready;
  logic [2:0][DW-1:0] vin_data = '0;
  logic [2:0]         path_valid;
  logic [2:0]         path_ready = 3'b111;
  logic [2:0][DW-1:0] path_data;

  int n_checks = 0;
  int n_fail   = 0;
  int bm [3];   // bench routing model: destination of each source

  logic [DW-1:0] q0 [$];
  logic [DW-1:0] q1 [$];
  logic [DW-1:0] q2 [$];

  always #4 clk = ~clk;

  phase_vroute #(.DATA_W(DW), .CFG_W(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .vin_valid(vin_valid), .vin_ready(vin_ready), .vin_data(vin_data),
    .path_valid(path_valid), .path_ready(path_ready), .path_data(path_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_exp(input int p, input logic [DW-1:0] d);
    case (p)
      0: q0.push_back(d);
      1: q1.push_back(d);
      default: q2.push_back(d);
    endcase
  endtask

  // Model routing from the requirements: rotation by code, 11 acts as 00.
  task automatic set_model(input logic [CW-1:0] v);
    for (int s = 0; s < 3; s++) begin
      int c;
      c = int'(v[8 + 2*s +: 2]);
      if (c == 3) c = 0;
      bm[s] = (s + c) % 3;
    end
  endtask

  function automatic bit wins(input int s);
    for (int o = 0; o < s; o++) if (bm[o] == bm[s]) return 1'b0;
    return 1'b1;
  endfunction

  // Called just after a posedge; returns just after the accepting posedge.
  task automatic send(input int s, input logic [DW-1:0] d);
    logic r;
    vin_valid[s] = 1'b1;
    vin_data[s]  = d;
    forever begin
      @(negedge clk); r = vin_ready[s];
      @(posedge clk); #1;
      if (r) break;
    end
    if (wins(s)) push_exp(bm[s], d);
    vin_valid[s] = 1'b0;
  endtask

  task automatic write_cfg(input logic [CW-1:0] v);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
    repeat (2) @(posedge clk); #1;
  endtask

  task automatic route(input logic [CW-1:0] v);
    write_cfg(v);
    set_model(v);
  endtask

  task automatic drain();
    repeat (4) @(posedge clk); #1;
    check("R7 scoreboard empty", q0.size() + q1.size() + q2.size(), 0);
  endtask

  // Monitor: compare every path handshake against the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < 3; p++) begin
        if (path_valid[p] && path_ready[p]) begin
          logic [DW-1:0] e;
          int sz;
          sz = (p == 0) ? q0.size() : (p == 1) ? q1.size() : q2.size();
          if (sz == 0) begin
            n_checks++; n_fail++;
            $display("FAIL R7 unexpected sample on path %0d actual=%0h expected=none", p, path_data[p]);
          end else begin
            e = (p == 0) ? q0.pop_front() : (p == 1) ? q1.pop_front() : q2.pop_front();
            check($sformatf("R2 R3 R4 routing path %0d", p), path_data[p], e);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    set_model('0);
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1 and R8 reset state
    check("R1 reset read", cfg_rd_data, 0);
    check("R8 reset valid", path_valid, 0);
    check("R8 reset data", path_data[0] | path_data[1] | path_data[2], 0);
    @(posedge clk); #1;

    // R2 R3 R4: straight routing with codes 00
    send(0, 24'h0A0001); send(1, 24'h0B0001); send(2, 24'h0C0001);
    drain();

    // R1 readback masking; R5 code 11 equals 00
    route(16'hFFFF);
    check("R1 masked read", cfg_rd_data, 16'h3F00);
    send(0, 24'h0A0011); send(1, 24'h0B0011); send(2, 24'h0C0011);
    drain();
    check("R5 code 11 straight", q0.size(), 0);

    // R2 R3 R4 codes 10: A->C, B->A, C->B
    route(16'h2A00);
    check("R1 readback", cfg_rd_data, 16'h2A00);
    send(0, 24'h0A0010); send(1, 24'h0B0010); send(2, 24'h0C0010);
    drain();

    // R6 full rotation: path A carries source C
    route(16'h1500);
    send(2, 24'h0C0006);
    @(negedge clk);
    check("R6 path A carries C", path_data[0], 24'h0C0006);
    check("R11 valid after accept", path_valid[0], 1);
    @(posedge clk); #1;
    send(0, 24'h0A0006); send(1, 24'h0B0006);
    drain();

    // R7 conflict A->B and B->B: A wins, B discarded; R8 path A untargeted
    route(16'h0100);
    send(1, 24'h0B0007);
    @(negedge clk);
    check("R7 loser not shown", path_valid, 0);
    check("R8 idle path A data", path_data[0], 0);
    @(posedge clk); #1;
    send(0, 24'h0A0007);
    @(negedge clk);
    check("R8 idle path A valid", path_valid[0], 0);
    check("R11 winner on path B", path_valid[1], 1);
    @(posedge clk); #1;
    drain();

    // R7 conflict C->A vs A->A: A wins, C discarded, path C idle
    route(16'h1000);
    send(2, 24'h0C0017);
    send(0, 24'h0A0017);
    drain();

    // R9 and R10: write routing while path A is stalled
    route(16'h0000);
    path_ready[0] = 1'b0;
    send(0, 24'h0A0009);
    vin_valid[0] = 1'b1; vin_data[0] = 24'h0A0099;
    @(negedge clk);
    check("R10 winner ready low when full", vin_ready[0], 0);
    vin_valid[0] = 1'b0;
    @(posedge clk); #1;
    write_cfg(16'h1500);
    send(1, 24'h0B0009);   // old map still in force: goes to path B
    @(negedge clk);
    check("R9 old map path B", path_valid[1], 1);
    check("R9 not on path C", path_valid[2], 0);
    check("R10 stalled data held", path_data[0], 24'h0A0009);
    check("R10 stalled valid held", path_valid[0], 1);
    @(posedge clk); #1;
    path_ready[0] = 1'b1;
    repeat (2) @(posedge clk); #1;
    set_model(16'h1500);
    send(0, 24'h0A0019);   // new map: A goes to path B
    @(negedge clk);
    check("R9 new map applied", path_valid[1], 1);
    @(posedge clk); #1;
    drain();

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule